// File: doc/BRIEF.md
# SDRAM Write Command Sequencer

This block turns write requests into SDRAM command sequences for one chip select. Each request names a bank, a row, a starting column and a word count, and carries up to eight data words with their byte enables. The sequencer opens the row when needed, issues the write command and then streams the burst. It spaces its commands with programmable activate-to-write, precharge-to-activate and write-recovery counts.

It tracks the open row of every bank, so a write to an open row goes straight to the write command. A mode input picks a 32-bit bus with bursts of four, or a 16-bit bus with bursts of eight. When a request ends before its burst does, the unused beats are masked. A following request may cut the burst short: with a new write on the same row, with a precharge when the bank is the same but the row differs, or with a burst-terminate when the bank differs.

Top module: `sdram_wr_seq`

## Requirements
- R1: A write to a bank with no open row issues activate, with the request's bank on BA and its row on A, in the first cycle after acceptance that the precharge-to-activate spacing allows. The write command follows.
- R2: The write command drives the request's bank on BA and the column on A, with A[10] held at 0.
- R3: Data word 0 is driven on DQ in the write-command cycle, and word k in the k-th cycle after it, with NOP on the command pins. Word k of a request sits at req_data[32k+31:32k], and its byte enables at req_be[4k+3:4k]. DQM for each byte lane is the inverse of its enable, so 1 masks the lane.
- R4: mode16 = 0 gives a burst of 4 beats on the full 32-bit bus. mode16 = 1 gives a burst of 8 beats on DQ[15:0], using the low half of each word, with DQM[3:2] at 1 and DQ[31:16] at 0. The mode is taken when the request is accepted.
- R5: Beats from index req_len up to the end of the burst drive DQM all ones. In every cycle that carries no request data, DQM is all ones.
- R6: A request to the open row of the bank being written, if accepted during a burst, issues a new write command in the cycle after acceptance. This gives back-to-back data with no gap.
- R7: A request to another row of the same bank issues precharge, with that bank on BA and A[10] at 0. Activate of the new row follows, then the write command.
- R8: A request to a different bank accepted while beats of the current burst remain issues burst-terminate in the cycle after acceptance, then continues its own sequence. If it is accepted on the final beat, no burst-terminate is issued.
- R9: Write follows activate by at least max(t_rcd,1) cycles, and activate follows precharge by at least max(t_rp,1) cycles. Precharge follows the cycle of the last request data word by at least max(t_wr,1) cycles. NOPs fill any wait.
- R10: A request to the row already open in its bank issues no activate. Its write command appears in the first cycle after acceptance that timing allows.
- R11: req_ready is 1 when the block is idle. During a burst it is 1 from the beat with index req_len-1 onwards, beat 0 being the write-command cycle. It is 0 while precharge, activate, burst-terminate or the write command is pending.
- R12: While rst_n is low, sd_cs_n is 1, the command pins show NOP, DQM is all ones and all banks are closed. After reset sd_cs_n is 0 and req_ready is 1.
- R13: The command codes on (sd_ras_n, sd_cas_n, sd_we_n) are NOP 111, activate 011, write 100, precharge 010 and burst-terminate 110.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode16 | input | 1 | 0: 32-bit bus, burst 4; 1: 16-bit bus, burst 8 |
| t_rcd | input | 4 | Minimum activate-to-write spacing in cycles |
| t_rp | input | 4 | Minimum precharge-to-activate spacing in cycles |
| t_wr | input | 4 | Minimum last-data-to-precharge spacing in cycles |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_bank | input | 2 | Target bank |
| req_row | input | 13 | Target row |
| req_col | input | 9 | Starting column |
| req_len | input | 4 | Number of words, 1 up to the burst length |
| req_data | input | 256 | Write words, word k at bits 32k+31:32k |
| req_be | input | 32 | Byte enables, word k at bits 4k+3:4k, 1 writes the byte |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_a | output | 13 | Row or column address |
| sd_dq | output | 32 | Write data |
| sd_dqm | output | 4 | Byte masks, 1 masks the lane |

## Verification
A stale entry in the open-row table shows at once at the pins. A wrong table hit drops the activate and puts the write command in the first cycle after acceptance. A missed hit adds an activate, or a precharge and an activate, before it. A burst-index or length register that is off by one moves the first masked beat or the end of the burst by one cycle, which shows in DQM within eight cycles of the write command. A timing counter that is wrong moves the next command one or more cycles away from its exact expected slot.

// File: rtl/sdwr_pkg.sv
package sdwr_pkg;

   // Pin code order is {ras_n, cas_n, we_n} with chip select low
   typedef enum logic [2:0] {
      CMD_ACT = 3'b011,
      CMD_WRT = 3'b100,
      CMD_PRE = 3'b010,
      CMD_BT  = 3'b110,
      CMD_NOP = 3'b111
   } sd_cmd_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_PRE,
      S_ACT,
      S_WRT,
      S_BT,
      S_BURST
   } seq_state_e;

endpackage

// File: rtl/sdwr_gap_timer.sv
module sdwr_gap_timer #(
   parameter int TM_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [TM_W-1:0] tval,
   output logic            expired
);

   logic [TM_W-1:0] cnt_q;

   if (TM_W < 1) begin : g_bad_width
      $error("sdwr_gap_timer: TM_W must be at least 1");
   end

   // Loading t-1 gives a spacing of max(t,1) between the two commands
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= (tval == '0) ? '0 : tval - 1'b1;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

   // R9: an idle running count steps down by exactly one
   p_count_down_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sdwr_row_table.sv
module sdwr_row_table #(
   parameter int NUM_BANKS = 4,
   parameter int BA_W      = 2,
   parameter int ROW_W     = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             open_en,
   input  logic             close_en,
   input  logic [BA_W-1:0]  upd_bank,
   input  logic [ROW_W-1:0] upd_row,
   input  logic [BA_W-1:0]  q_bank,
   input  logic [ROW_W-1:0] q_row,
   output logic             q_open,
   output logic             q_hit
);

   logic [NUM_BANKS-1:0] vld;
   logic [ROW_W-1:0]     rows [NUM_BANKS];

   if (NUM_BANKS != (1 << BA_W)) begin : g_bad_banks
      $error("sdwr_row_table: NUM_BANKS must equal 2**BA_W");
   end

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic             v_q;
      logic [ROW_W-1:0] r_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            r_q <= '0;
         end else if (open_en && upd_bank == BA_W'(b)) begin
            v_q <= 1'b1;
            r_q <= upd_row;
         end else if (close_en && upd_bank == BA_W'(b)) begin
            v_q <= 1'b0;
         end
      end
      assign vld[b]  = v_q;
      assign rows[b] = r_q;
   end

   assign q_open = vld[q_bank];
   assign q_hit  = vld[q_bank] && (rows[q_bank] == q_row);

   // R7: a bank is never opened and closed in the same cycle
   p_open_close_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(open_en && close_en));

endmodule

// File: rtl/sdwr_beat_mux.sv
module sdwr_beat_mux #(
   parameter int DQ_W   = 32,
   parameter int NB     = 4,
   parameter int BL_MAX = 8,
   parameter int LEN_W  = 4
) (
   input  logic [BL_MAX*DQ_W-1:0] data,
   input  logic [BL_MAX*NB-1:0]   be,
   input  logic [LEN_W-1:0]       idx,
   input  logic [LEN_W-1:0]       len,
   input  logic                   active,
   input  logic                   half,
   output logic [DQ_W-1:0]        dq,
   output logic [NB-1:0]          dqm
);

   localparam int HB = NB / 2;

   logic [DQ_W-1:0] word;
   logic [NB-1:0]   bew;
   logic            real_beat;

   always_comb begin
      word = '0;
      bew  = '0;
      for (int k = 0; k < BL_MAX; k++) begin
         if (idx == LEN_W'(k)) begin
            word = data[k*DQ_W +: DQ_W];
            bew  = be[k*NB +: NB];
         end
      end
   end

   assign real_beat = active && (idx < len);

   for (genvar l = 0; l < NB; l++) begin : g_lane
      localparam bit UPPER = (l >= HB);
      logic lane_on;
      assign lane_on          = real_beat && !(half && UPPER);
      assign dq[l*8 +: 8]     = lane_on ? word[l*8 +: 8] : 8'h00;
      assign dqm[l]           = lane_on ? ~bew[l] : 1'b1;
   end

endmodule

// File: rtl/sdram_wr_seq.sv
module sdram_wr_seq
   import sdwr_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int ROW_W     = 13,
   parameter int COL_W     = 9,
   parameter int ADDR_W    = 13,
   parameter int DQ_W      = 32,
   parameter int BL_MAX    = 8,
   parameter int TM_W      = 4,
   localparam int BA_W     = $clog2(NUM_BANKS),
   localparam int NB       = DQ_W / 8,
   localparam int LEN_W    = $clog2(BL_MAX + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   mode16,
   input  logic [TM_W-1:0]        t_rcd,
   input  logic [TM_W-1:0]        t_rp,
   input  logic [TM_W-1:0]        t_wr,
   input  logic                   req_valid,
   output logic                   req_ready,
   input  logic [BA_W-1:0]        req_bank,
   input  logic [ROW_W-1:0]       req_row,
   input  logic [COL_W-1:0]       req_col,
   input  logic [LEN_W-1:0]       req_len,
   input  logic [BL_MAX*DQ_W-1:0] req_data,
   input  logic [BL_MAX*NB-1:0]   req_be,
   output logic                   sd_cs_n,
   output logic                   sd_ras_n,
   output logic                   sd_cas_n,
   output logic                   sd_we_n,
   output logic [BA_W-1:0]        sd_ba,
   output logic [ADDR_W-1:0]      sd_a,
   output logic [DQ_W-1:0]        sd_dq,
   output logic [NB-1:0]          sd_dqm
);

   localparam int HALF_BL = BL_MAX / 2;
   localparam int GAP_W   = TM_W + 1;

   if (NUM_BANKS < 2 || NUM_BANKS != (1 << BA_W)) begin : g_bad_banks
      $error("sdram_wr_seq: NUM_BANKS must be a power of two, at least 2");
   end
   if (ADDR_W < 11 || COL_W > 10 || ROW_W > ADDR_W) begin : g_bad_addr
      $error("sdram_wr_seq: address bit 10 must exist and lie above the column");
   end
   if (DQ_W % 16 != 0 || BL_MAX < 2 || BL_MAX % 2 != 0) begin : g_bad_data
      $error("sdram_wr_seq: DQ_W must be a multiple of 16, BL_MAX even");
   end

   seq_state_e               st_q, st_d, after_bt_q, after_bt_d;
   logic [BA_W-1:0]          bank_q;
   logic [ROW_W-1:0]         row_q;
   logic [COL_W-1:0]         col_q;
   logic [LEN_W-1:0]         len_q, idx_q, idx_d, beat_idx, bl_w, req_bl, len_eff;
   logic                     half_q, cs_n_q;
   logic [BL_MAX*DQ_W-1:0]   data_q;
   logic [BL_MAX*NB-1:0]     be_q;
   sd_cmd_e                  cmd;
   logic [BA_W-1:0]          ba_o;
   logic [ADDR_W-1:0]        a_o;
   logic                     beat_act, accept, mid_burst;
   logic                     tbl_open, tbl_hit;
   logic                     rcd_ok, rp_ok, wr_ok, wr_load;

   function automatic seq_state_e pick_path(input logic open, input logic hit);
      if (hit)       return S_WRT;
      else if (open) return S_PRE;
      else           return S_ACT;
   endfunction

   assign bl_w      = half_q ? LEN_W'(BL_MAX) : LEN_W'(HALF_BL);
   assign req_bl    = mode16 ? LEN_W'(BL_MAX) : LEN_W'(HALF_BL);
   assign len_eff   = (req_len == '0) ? LEN_W'(1) :
                      (req_len > req_bl) ? req_bl : req_len;
   assign req_ready = (st_q == S_IDLE) ||
                      (st_q == S_BURST && idx_q >= len_q - 1'b1);
   assign accept    = req_valid && req_ready;
   assign mid_burst = (idx_q < bl_w - 1'b1);

   sdwr_row_table #(
      .NUM_BANKS (NUM_BANKS),
      .BA_W      (BA_W),
      .ROW_W     (ROW_W)
   ) u_rows (
      .clk      (clk),
      .rst_n    (rst_n),
      .open_en  (cmd == CMD_ACT),
      .close_en (cmd == CMD_PRE),
      .upd_bank (bank_q),
      .upd_row  (row_q),
      .q_bank   (req_bank),
      .q_row    (req_row),
      .q_open   (tbl_open),
      .q_hit    (tbl_hit)
   );

   sdwr_gap_timer #(.TM_W(TM_W)) u_rcd (
      .clk(clk), .rst_n(rst_n), .load(cmd == CMD_ACT), .tval(t_rcd), .expired(rcd_ok));
   sdwr_gap_timer #(.TM_W(TM_W)) u_rp (
      .clk(clk), .rst_n(rst_n), .load(cmd == CMD_PRE), .tval(t_rp), .expired(rp_ok));
   sdwr_gap_timer #(.TM_W(TM_W)) u_wr (
      .clk(clk), .rst_n(rst_n), .load(wr_load), .tval(t_wr), .expired(wr_ok));

   always_comb begin
      cmd        = CMD_NOP;
      ba_o       = '0;
      a_o        = '0;
      beat_act   = 1'b0;
      beat_idx   = idx_q;
      st_d       = st_q;
      idx_d      = idx_q;
      after_bt_d = after_bt_q;
      case (st_q)
         S_IDLE: begin
            if (accept) st_d = pick_path(tbl_open, tbl_hit);
         end
         S_PRE: begin
            if (wr_ok) begin
               cmd  = CMD_PRE;
               ba_o = bank_q;
               st_d = S_ACT;
            end
         end
         S_ACT: begin
            if (rp_ok) begin
               cmd  = CMD_ACT;
               ba_o = bank_q;
               a_o  = ADDR_W'(row_q);
               st_d = S_WRT;
            end
         end
         S_WRT: begin
            if (rcd_ok) begin
               cmd      = CMD_WRT;
               ba_o     = bank_q;
               a_o      = ADDR_W'(col_q);
               a_o[10]  = 1'b0;
               beat_act = 1'b1;
               beat_idx = '0;
               st_d     = S_BURST;
               idx_d    = LEN_W'(1);
            end
         end
         S_BT: begin
            cmd  = CMD_BT;
            st_d = after_bt_q;
         end
         S_BURST: begin
            beat_act = 1'b1;
            if (accept) begin
               if (mid_burst && req_bank != bank_q) begin
                  st_d       = S_BT;
                  after_bt_d = pick_path(tbl_open, tbl_hit);
               end else begin
                  st_d = pick_path(tbl_open, tbl_hit);
               end
            end else if (!mid_burst) begin
               st_d = S_IDLE;
            end else begin
               idx_d = idx_q + 1'b1;
            end
         end
         default: st_d = S_IDLE;
      endcase
   end

   assign wr_load = beat_act && (beat_idx == len_q - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= S_IDLE;
         after_bt_q <= S_IDLE;
         idx_q      <= '0;
         cs_n_q     <= 1'b1;
         bank_q     <= '0;
         row_q      <= '0;
         col_q      <= '0;
         len_q      <= LEN_W'(1);
         half_q     <= 1'b0;
         data_q     <= '0;
         be_q       <= '0;
      end else begin
         st_q       <= st_d;
         after_bt_q <= after_bt_d;
         idx_q      <= idx_d;
         cs_n_q     <= 1'b0;
         if (accept) begin
            bank_q <= req_bank;
            row_q  <= req_row;
            col_q  <= req_col;
            len_q  <= len_eff;
            half_q <= mode16;
            data_q <= req_data;
            be_q   <= req_be;
         end
      end
   end

   sdwr_beat_mux #(
      .DQ_W   (DQ_W),
      .NB     (NB),
      .BL_MAX (BL_MAX),
      .LEN_W  (LEN_W)
   ) u_beat (
      .data   (data_q),
      .be     (be_q),
      .idx    (beat_idx),
      .len    (len_q),
      .active (beat_act),
      .half   (half_q),
      .dq     (sd_dq),
      .dqm    (sd_dqm)
   );

   assign sd_cs_n = cs_n_q;
   assign {sd_ras_n, sd_cas_n, sd_we_n} = cmd;
   assign sd_ba = ba_o;
   assign sd_a  = a_o;

   // Cycle distances since the last activate, precharge and final data word
   logic [GAP_W-1:0] since_act_q, since_pre_q, since_dat_q;
   logic [GAP_W-1:0] min_rcd, min_rp, min_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_act_q <= '1;
         since_pre_q <= '1;
         since_dat_q <= '1;
      end else begin
         since_act_q <= (cmd == CMD_ACT) ? GAP_W'(1) :
                        (since_act_q == '1) ? since_act_q : since_act_q + 1'b1;
         since_pre_q <= (cmd == CMD_PRE) ? GAP_W'(1) :
                        (since_pre_q == '1) ? since_pre_q : since_pre_q + 1'b1;
         since_dat_q <= wr_load ? GAP_W'(1) :
                        (since_dat_q == '1) ? since_dat_q : since_dat_q + 1'b1;
      end
   end

   assign min_rcd = (t_rcd == '0) ? GAP_W'(1) : GAP_W'(t_rcd);
   assign min_rp  = (t_rp  == '0) ? GAP_W'(1) : GAP_W'(t_rp);
   assign min_wr  = (t_wr  == '0) ? GAP_W'(1) : GAP_W'(t_wr);

   p_rcd_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_WRT) |-> (since_act_q >= min_rcd));

   p_rp_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_ACT) |-> (since_pre_q >= min_rp));

   p_wr_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_PRE) |-> (since_dat_q >= min_wr));

   // R8: burst-terminate only ever follows a burst beat
   p_bt_after_beat_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_BT) |-> ($past(st_q) == S_BURST));

   // R4: the beat counter never reaches the burst length
   p_beat_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_BURST) |-> (idx_q < bl_w));

endmodule

// File: tb/sdram_wr_seq_bench.sv
module sdram_wr_seq_bench;

   localparam logic [2:0] C_NOP = 3'b111;
   localparam logic [2:0] C_ACT = 3'b011;
   localparam logic [2:0] C_WRT = 3'b100;
   localparam logic [2:0] C_PRE = 3'b010;
   localparam logic [2:0] C_BT  = 3'b110;
   localparam int LOGN = 1024;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         mode16 = 1'b0;
   logic [3:0]   t_rcd = 4'd2, t_rp = 4'd3, t_wr = 4'd2;
   logic         req_valid = 1'b0;
   logic         req_ready;
   logic [1:0]   req_bank = '0;
   logic [12:0]  req_row = '0;
   logic [8:0]   req_col = '0;
   logic [3:0]   req_len = 4'd1;
   logic [255:0] req_data = '0;
   logic [31:0]  req_be = '0;
   logic         sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
   logic [1:0]   sd_ba;
   logic [12:0]  sd_a;
   logic [31:0]  sd_dq;
   logic [3:0]   sd_dqm;

   int nchk = 0;
   int nfail = 0;
   int cyc = 0;
   bit reported = 0;

   logic [2:0]  lcmd [LOGN];
   logic [1:0]  lba  [LOGN];
   logic [12:0] la   [LOGN];
   logic [31:0] ldq  [LOGN];
   logic [3:0]  ldqm [LOGN];
   logic        lrdy [LOGN];

   sdram_wr_seq u_sdram_wr_seq (
      .clk(clk), .rst_n(rst_n), .mode16(mode16),
      .t_rcd(t_rcd), .t_rp(t_rp), .t_wr(t_wr),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
      .req_len(req_len), .req_data(req_data), .req_be(req_be),
      .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
      .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_a(sd_a),
      .sd_dq(sd_dq), .sd_dqm(sd_dqm));

   always #5 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (cyc < LOGN) begin
         lcmd[cyc] <= {sd_ras_n, sd_cas_n, sd_we_n};
         lba[cyc]  <= sd_ba;
         la[cyc]   <= sd_a;
         ldq[cyc]  <= sd_dq;
         ldqm[cyc] <= sd_dqm;
         lrdy[cyc] <= req_ready;
      end
   end

   function automatic logic [31:0] mkword(input logic [7:0] seed, input int k);
      return {seed, 8'(k * 17 + 1), ~seed, 8'(k)};
   endfunction

   function automatic logic [3:0] mkbe(input int k);
      return (k == 1) ? 4'h6 : (k == 2) ? 4'h9 : 4'hF;
   endfunction

   task automatic chk(input bit ok, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   task automatic report();
      if (!reported) begin
         reported = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      end
   endtask

   // Called at a falling edge; returns at the falling edge of the first
   // cycle after acceptance, with acc set to that cycle's number
   task automatic send(input logic [1:0] b, input logic [12:0] r,
                       input logic [8:0] c, input logic [3:0] n, input logic m,
                       input logic [7:0] seed, output int acc);
      req_bank = b; req_row = r; req_col = c; req_len = n; mode16 = m;
      for (int k = 0; k < 8; k++) begin
         req_data[k*32 +: 32] = mkword(seed, k);
         req_be[k*4 +: 4]     = mkbe(k);
      end
      req_valid = 1'b1;
      while (!req_ready) @(negedge clk);
      acc = cyc + 1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic wait_log(input int w);
      while (cyc <= w + 1) @(negedge clk);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check_cmd(input int w, input logic [2:0] exp, input string tag);
      chk(lcmd[w] == exp, $sformatf("%s cmd @%0d", tag, w), 32'(lcmd[w]), 32'(exp));
   endtask

   task automatic check_beat(input int w, input logic [7:0] seed, input int k,
                             input bit m, input bit real_word, input string tag);
      logic [31:0] edq;
      logic [3:0]  edqm;
      if (!real_word) begin
         edq = 32'h0; edqm = 4'hF;
      end else if (m) begin
         edq = {16'h0, mkword(seed, k)[15:0]}; edqm = {2'b11, ~mkbe(k)[1:0]};
      end else begin
         edq = mkword(seed, k); edqm = ~mkbe(k);
      end
      chk(ldqm[w] == edqm, $sformatf("%s dqm beat %0d @%0d", tag, k, w),
          32'(ldqm[w]), 32'(edqm));
      if (real_word)
         chk(ldq[w] == edq, $sformatf("%s dq beat %0d @%0d", tag, k, w), ldq[w], edq);
      if (k != 0) check_cmd(w, C_NOP, {tag, " R3 beat NOP R13"});
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(sd_cs_n == 1'b1, "R12 cs_n in reset", 32'(sd_cs_n), 32'h1);
      chk({sd_ras_n, sd_cas_n, sd_we_n} == C_NOP, "R12 cmd in reset",
          32'({sd_ras_n, sd_cas_n, sd_we_n}), 32'(C_NOP));
      chk(sd_dqm == 4'hF, "R12 dqm in reset", 32'(sd_dqm), 32'hF);
      rst_n = 1'b1;
      idle(2);
      chk(sd_cs_n == 1'b0, "R12 cs_n after reset", 32'(sd_cs_n), 32'h0);
      chk(req_ready == 1'b1, "R12 R11 ready after reset", 32'(req_ready), 32'h1);
      chk(sd_dqm == 4'hF, "R5 dqm idle", 32'(sd_dqm), 32'hF);
   endtask

   // Closed bank: activate, then write after t_rcd
   task automatic t_closed_bank();
      int a;
      send(2'd0, 13'h123, 9'h010, 4'd4, 1'b0, 8'h11, a);
      wait_log(a + 6);
      check_cmd(a, C_ACT, "R1 R13 activate");
      chk(lba[a] == 2'd0 && la[a] == 13'h123, "R1 activate bank/row",
          {17'h0, lba[a], la[a]}, {17'h0, 2'd0, 13'h123});
      chk(lrdy[a] == 1'b0, "R11 ready low while opening", 32'(lrdy[a]), 32'h0);
      check_cmd(a + 1, C_NOP, "R9 no early write");
      check_cmd(a + 2, C_WRT, "R9 R2 write after t_rcd");
      chk(la[a+2] == 13'h010 && lba[a+2] == 2'd0, "R2 write column/bank",
          {17'h0, lba[a+2], la[a+2]}, {17'h0, 2'd0, 13'h010});
      for (int k = 0; k < 4; k++) check_beat(a + 2 + k, 8'h11, k, 0, 1, "R3");
      check_cmd(a + 6, C_NOP, "R4 burst of four ends");
      idle(10);
   endtask

   // Row hit: no activate; short request masks the tail
   task automatic t_hit_short();
      int a;
      send(2'd0, 13'h123, 9'h420, 4'd2, 1'b0, 8'h22, a);
      wait_log(a + 4);
      check_cmd(a, C_WRT, "R10 hit writes at once");
      chk(la[a][10] == 1'b0, "R2 A10 low", 32'(la[a][10]), 32'h0);
      chk(la[a] == 13'h020, "R2 column bits", 32'(la[a]), 32'h020);
      check_beat(a,     8'h22, 0, 0, 1, "R3");
      check_beat(a + 1, 8'h22, 1, 0, 1, "R3");
      check_beat(a + 2, 8'h22, 2, 0, 0, "R5 masked");
      check_beat(a + 3, 8'h22, 3, 0, 0, "R5 masked");
      chk(lrdy[a+1] == 1'b1, "R11 ready at last word", 32'(lrdy[a+1]), 32'h1);
      idle(10);
   endtask

   // Same page: second write follows the last word at once
   task automatic t_same_page();
      int a1, a2;
      send(2'd0, 13'h123, 9'h040, 4'd2, 1'b0, 8'h33, a1);
      send(2'd0, 13'h123, 9'h048, 4'd3, 1'b0, 8'h44, a2);
      wait_log(a1 + 6);
      chk(a2 == a1 + 2, "R6 R11 second accepted at last word", 32'(a2), 32'(a1 + 2));
      check_cmd(a1, C_WRT, "R10 first write");
      check_beat(a1 + 1, 8'h33, 1, 0, 1, "R3");
      check_cmd(a1 + 2, C_WRT, "R6 truncating write");
      chk(la[a1+2] == 13'h048, "R6 new column", 32'(la[a1+2]), 32'h048);
      check_beat(a1 + 2, 8'h44, 0, 0, 1, "R6");
      check_beat(a1 + 4, 8'h44, 2, 0, 1, "R6");
      check_beat(a1 + 5, 8'h44, 3, 0, 0, "R5 masked");
      idle(10);
   endtask

   // Same bank, other row: precharge, activate, write
   task automatic t_other_row();
      int a1, a2;
      send(2'd0, 13'h123, 9'h060, 4'd1, 1'b0, 8'h55, a1);
      send(2'd0, 13'h055, 9'h070, 4'd1, 1'b0, 8'h66, a2);
      wait_log(a1 + 8);
      check_cmd(a1 + 1, C_NOP, "R9 t_wr wait");
      check_cmd(a1 + 2, C_PRE, "R7 R9 precharge truncates");
      chk(lba[a1+2] == 2'd0 && la[a1+2][10] == 1'b0, "R7 precharge bank, A10 low",
          {29'h0, lba[a1+2], la[a1+2][10]}, 32'h0);
      check_cmd(a1 + 4, C_NOP, "R9 t_rp wait");
      check_cmd(a1 + 5, C_ACT, "R7 R9 activate after t_rp");
      chk(la[a1+5] == 13'h055, "R7 new row", 32'(la[a1+5]), 32'h055);
      check_cmd(a1 + 7, C_WRT, "R7 write new row");
      chk(ldqm[a1+3] == 4'hF, "R5 dqm during precharge wait", 32'(ldqm[a1+3]), 32'hF);
      idle(12);
   endtask

   // Other bank mid-burst: burst-terminate first
   task automatic t_other_bank();
      int a1, a2;
      send(2'd0, 13'h055, 9'h080, 4'd1, 1'b0, 8'h77, a1);
      send(2'd1, 13'h0AA, 9'h090, 4'd2, 1'b0, 8'h88, a2);
      wait_log(a1 + 7);
      check_cmd(a1, C_WRT, "R10 hit in bank 0");
      check_cmd(a1 + 2, C_BT, "R8 R13 burst-terminate");
      check_cmd(a1 + 3, C_ACT, "R8 R1 activate other bank");
      chk(lba[a1+3] == 2'd1 && la[a1+3] == 13'h0AA, "R1 bank 1 row",
          {17'h0, lba[a1+3], la[a1+3]}, {17'h0, 2'd1, 13'h0AA});
      check_cmd(a1 + 5, C_WRT, "R8 write other bank");
      check_beat(a1 + 6, 8'h88, 1, 0, 1, "R3");
      idle(12);
   endtask

   // 16-bit mode: burst of eight on the low half
   task automatic t_half_bus();
      int a;
      send(2'd1, 13'h0AA, 9'h100, 4'd5, 1'b1, 8'h99, a);
      wait_log(a + 9);
      check_cmd(a, C_WRT, "R10 R4 write");
      for (int k = 0; k < 8; k++) check_beat(a + k, 8'h99, k, 1, k < 5, "R4");
      check_cmd(a + 8, C_NOP, "R4 burst of eight ends");
      chk(ldqm[a+8] == 4'hF, "R5 dqm after burst", 32'(ldqm[a+8]), 32'hF);
      idle(10);
   endtask

   // Other bank on the final beat: no burst-terminate
   task automatic t_natural_end();
      int a1, a2;
      send(2'd1, 13'h0AA, 9'h004, 4'd4, 1'b0, 8'hAB, a1);
      send(2'd0, 13'h055, 9'h00C, 4'd1, 1'b0, 8'hCD, a2);
      wait_log(a1 + 6);
      chk(a2 == a1 + 4, "R11 accepted on last beat", 32'(a2), 32'(a1 + 4));
      check_cmd(a1 + 4, C_WRT, "R8 no terminate after final beat");
      chk(lba[a1+4] == 2'd0, "R2 bank 0", 32'(lba[a1+4]), 32'h0);
      check_beat(a1 + 4, 8'hCD, 0, 0, 1, "R3");
      idle(10);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_closed_bank();
      t_hit_short();
      t_same_page();
      t_other_row();
      t_other_bank();
      t_half_bus();
      t_natural_end();
      report();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      nchk++;
      nfail++;
      $display("FAIL watchdog expired");
      report();
      $finish;
   end

endmodule